// File: doc/BRIEF.md
# Level-Interrupt GPIO Port

A 32-pin general-purpose I/O port with a per-pin level-sensitive interrupt detector and a mask/pending stage. The port drives one combined interrupt line to a host. Each pin has a direction bit and an output latch. The input side passes through a two-flop synchroniser. That synchronised value feeds both the data readback and the interrupt detector.

A pin raises its status bit on every cycle in which its synchronised level matches the polarity chosen for it. Software clears a status bit by writing a zero to it. A one written to a status bit leaves that bit as it is. If the level is still present, the bit sets again on the next cycle. A separate interrupt window shows the raw status bits as pending and holds a mask register. The mask comes out of reset with every pin blocked. The interrupt output is registered, and it rises when any pending bit is not masked.

Registers are reached through a simple word-wide bus with single-cycle read and write strobes. The GPIO window starts at offset 0x00. The interrupt window starts at parameter `IRQ_BASE`, which defaults to 0x10. Every access is a full 32-bit word.

Top module: `gpio_lvl_port`

## Requirements
- R1: After reset, `gpio_oe_o` and `gpio_o` are all zero, `irq_o` is low, and the mask register reads 0xFFFFFFFF.
- R2: Writing offset 0x00 (direction) sets `gpio_oe_o`, where a 1 makes that pin an output. Writing offset 0x04 (data) sets the output latch, which appears on `gpio_o`.
- R3: Reading offset 0x04 returns the pin levels after the two-flop synchroniser. A change on `gpio_i` is visible from the third clock edge onwards.
- R4: Offset 0x08 holds the polarity. A bit at 1 makes its pin interrupt on a high level, and a bit at 0 makes it interrupt on a low level. A status bit sets on any edge at which the synchronised pin matches its polarity. No edge detection exists.
- R5: Offset 0x0C holds the status. A written 0 clears that bit and a written 1 leaves it unchanged. If the level still matches, the bit sets again on the next edge, so the set condition wins over the clear.
- R6: The pending register at `IRQ_BASE`+0x00 reads the status bits, whatever the mask holds.
- R7: The mask register at `IRQ_BASE`+0x08 blocks a pin where its bit is 1. While every bit is 1, `irq_o` stays low.
- R8: `irq_o` is a register. It holds the OR of status AND NOT mask, taken one edge earlier.
- R9: A read from any other offset returns zero. This includes offsets whose low two bits are not zero. A write to any other offset changes no register.
- R10: `rdata_o` is loaded at the edge on which `rd_i` is high. It holds its value while `rd_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| wr_i | input | 1 | Single-cycle write strobe |
| rd_i | input | 1 | Single-cycle read strobe |
| rdata_o | output | 32 | Registered read data |
| gpio_i | input | 32 | Pad input levels (asynchronous) |
| gpio_o | output | 32 | Output latch to pads |
| gpio_oe_o | output | 32 | Output enable per pin |
| irq_o | output | 1 | Combined interrupt to the host |

## Verification
Directed patterns come first:
- With all pins low under low polarity, every status bit sets. Acknowledging one bit while its level persists must show the bit set again, which separates level behaviour from a latched edge.
- Raising a single pin before its acknowledge shows that the clear takes effect once the level is gone.
- Unmasking one pending pin, with all other bits still masked, separates raw pending from the gated interrupt output.

Random rounds then change polarity, pins, acknowledge and mask words. The bench model includes the status bits set by the intermediate pin and polarity combinations. The results therefore expose a missing OR in the status capture, an inverted polarity, or the wrong acknowledge sense.

// File: rtl/gpio_lvl_pkg.sv
package gpio_lvl_pkg;
  localparam int unsigned WORD_W = 32;
  // GPIO window offsets
  localparam logic [7:0] OFF_DIR  = 8'h00;
  localparam logic [7:0] OFF_DATA = 8'h04;
  localparam logic [7:0] OFF_POL  = 8'h08;
  localparam logic [7:0] OFF_STAT = 8'h0C;
  // interrupt window offsets, relative to its base
  localparam logic [7:0] OFF_PEND = 8'h00;
  localparam logic [7:0] OFF_MASK = 8'h08;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_lvl_detect.sv
module gpio_lvl_detect #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pin_i,
  input  logic [WIDTH-1:0] pol_i,
  input  logic             ack_we_i,
  input  logic [WIDTH-1:0] ack_keep_i,
  output logic [WIDTH-1:0] status_o
);
  logic [WIDTH-1:0] hit, status_q, status_kept;
  logic             started_q;

  assign hit         = ~(pin_i ^ pol_i);
  assign status_kept = ack_we_i ? (status_q & ack_keep_i) : status_q;

  // set has priority over acknowledge: level still present re-arms the bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q  <= '0;
      started_q <= 1'b0;
    end else begin
      status_q  <= status_kept | hit;
      started_q <= 1'b1;
    end
  end

  assign status_o = status_q;

  a_r4_match_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q |-> ((status_q & $past(hit)) == $past(hit)));

  a_r5_clear_needs_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && |($past(status_q) & ~status_q)) |-> $past(ack_we_i));
endmodule

// File: rtl/gpio_irq_agg.sv
module gpio_irq_agg #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mask_we_i,
  input  logic [WIDTH-1:0] mask_wdata_i,
  input  logic [WIDTH-1:0] status_i,
  output logic [WIDTH-1:0] mask_o,
  output logic             irq_o
);
  logic [WIDTH-1:0] mask_q;
  logic             irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      irq_q  <= 1'b0;
    end else begin
      if (mask_we_i) mask_q <= mask_wdata_i;
      irq_q <= |(status_i & ~mask_q);
    end
  end

  assign mask_o = mask_q;
  assign irq_o  = irq_q;

  a_r7_all_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_q) |=> !irq_o);

  a_r8_unmasked_fires: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(status_i & ~mask_q)) |=> irq_o);
endmodule

// File: rtl/gpio_lvl_port.sv
module gpio_lvl_port
  import gpio_lvl_pkg::*;
#(
  parameter int unsigned WIDTH    = WORD_W,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned SYNC_N   = 2,
  parameter logic [7:0]  IRQ_BASE = 8'h10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [WIDTH-1:0]  rdata_o,
  input  logic [WIDTH-1:0]  gpio_i,
  output logic [WIDTH-1:0]  gpio_o,
  output logic              irq_o,
  output logic [WIDTH-1:0]  gpio_oe_o
);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFF_DIR);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFF_DATA);
  localparam logic [ADDR_W-1:0] A_POL  = ADDR_W'(OFF_POL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(IRQ_BASE + OFF_PEND);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(IRQ_BASE + OFF_MASK);

  logic [WIDTH-1:0] dir_q, out_q, pol_q, rdata_q;
  logic [WIDTH-1:0] pin_sync, status, mask, rd_mux;
  logic             sel_dir, sel_data, sel_pol, sel_stat, sel_pend, sel_mask, sel_none;

  assign sel_dir  = (addr_i == A_DIR);
  assign sel_data = (addr_i == A_DATA);
  assign sel_pol  = (addr_i == A_POL);
  assign sel_stat = (addr_i == A_STAT);
  assign sel_pend = (addr_i == A_PEND);
  assign sel_mask = (addr_i == A_MASK);
  assign sel_none = !(sel_dir || sel_data || sel_pol || sel_stat || sel_pend || sel_mask);

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_N)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (gpio_i),
    .q_o   (pin_sync)
  );

  gpio_lvl_detect #(.WIDTH(WIDTH)) u_detect (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pin_i     (pin_sync),
    .pol_i     (pol_q),
    .ack_we_i  (wr_i && sel_stat),
    .ack_keep_i(wdata_i),
    .status_o  (status)
  );

  gpio_irq_agg #(.WIDTH(WIDTH)) u_agg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mask_we_i   (wr_i && sel_mask),
    .mask_wdata_i(wdata_i),
    .status_i    (status),
    .mask_o      (mask),
    .irq_o       (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
      out_q <= '0;
      pol_q <= '0;
    end else if (wr_i) begin
      if (sel_dir)  dir_q <= wdata_i;
      if (sel_data) out_q <= wdata_i;
      if (sel_pol)  pol_q <= wdata_i;
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (1'b1)
      sel_dir:  rd_mux = dir_q;
      sel_data: rd_mux = pin_sync;
      sel_pol:  rd_mux = pol_q;
      sel_stat: rd_mux = status;
      sel_pend: rd_mux = status;
      sel_mask: rd_mux = mask;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
  end

  assign rdata_o   = rdata_q;
  assign gpio_o    = out_q;
  assign gpio_oe_o = dir_q;

  a_r9_undef_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && sel_none) |=> (rdata_o == '0));

  a_r9_undef_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_none) |=> ($stable(gpio_oe_o) && $stable(gpio_o) && $stable(mask)));

  a_r10_rdata_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
endmodule

// File: tb/tb_gpio_lvl_port.sv
module tb_gpio_lvl_port;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        wr_i = 1'b0, rd_i = 1'b0;
  logic [31:0] rdata_o, gpio_i = '0, gpio_o, gpio_oe_o;
  logic        irq_o;

  int n_run = 0, n_fail = 0;
  logic [31:0] exp_stat, pins, pol, mask, rv;

  always #2ns clk_i = ~clk_i;

  gpio_lvl_port dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .wr_i(wr_i), .rd_i(rd_i), .rdata_o(rdata_o), .gpio_i(gpio_i),
    .gpio_o(gpio_o), .irq_o(irq_o), .gpio_oe_o(gpio_oe_o)
  );

  function automatic logic [31:0] hit_of(logic [31:0] p, logic [31:0] q);
    return ~(p ^ q);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk_i); addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i); wr_i = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i); addr_i = a; rd_i = 1'b1;
    @(negedge clk_i); rd_i = 1'b0; d = rdata_o;
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    #200us;
    n_run++; n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    settle(3);
    rst_ni = 1'b1;
    // R1 reset state
    chk("R1 oe", gpio_oe_o, 32'h0);
    chk("R1 out", gpio_o, 32'h0);
    chk("R1 irq", {31'h0, irq_o}, 32'h0);
    rd(8'h18, rv); chk("R1 mask", rv, 32'hFFFF_FFFF);
    pins = '0; pol = '0; mask = '1;
    exp_stat = hit_of(pins, pol);

    // R2 direction and output latch
    wr(8'h00, 32'hA5A5_0F0F); chk("R2 oe", gpio_oe_o, 32'hA5A5_0F0F);
    wr(8'h04, 32'h1234_5678); chk("R2 out", gpio_o, 32'h1234_5678);

    // R10 hold while rd_i low
    rd(8'h00, rv); settle(3); chk("R10 hold", rdata_o, 32'hA5A5_0F0F);

    // R3 synchronised readback: visible after 2 edges, not after 1
    @(negedge clk_i); gpio_i = 32'hDEAD_BEEF;
    @(negedge clk_i); addr_i = 8'h04; rd_i = 1'b1;
    @(negedge clk_i); rd_i = 1'b0; chk("R3 not yet", rdata_o, 32'h0);
    rd(8'h04, rv); chk("R3 data", rv, 32'hDEAD_BEEF);
    gpio_i = '0; settle(4);

    // R4/R5 level re-arm: pin low, pol low, ack bit 3 -> set again
    rd(8'h0C, rv); chk("R4 low pol", rv, 32'hFFFF_FFFF);
    wr(8'h0C, ~32'h8); rd(8'h0C, rv); chk("R5 rearm", rv, 32'hFFFF_FFFF);
    // R5: raise pin 3, then ack bit 3 -> stays clear; ones keep others
    gpio_i = 32'h8; pins = 32'h8; settle(4);
    wr(8'h0C, ~32'h8); rd(8'h0C, rv); chk("R5 ack clears", rv, ~32'h8);
    // R4 high polarity on bit 3 sets it again
    wr(8'h08, 32'h8); pol = 32'h8; settle(2);
    rd(8'h0C, rv); chk("R4 high pol", rv, 32'hFFFF_FFFF);
    exp_stat = 32'hFFFF_FFFF;

    // R6/R7 pending regardless of mask; irq low while all masked
    rd(8'h10, rv); chk("R6 pending", rv, 32'hFFFF_FFFF);
    chk("R7 masked", {31'h0, irq_o}, 32'h0);
    // R9 undefined offsets
    wr(8'h14, 32'h0); wr(8'h1C, 32'h0); wr(8'h02, 32'h0);
    rd(8'h18, rv); chk("R9 mask kept", rv, 32'hFFFF_FFFF);
    chk("R9 oe kept", gpio_oe_o, 32'hA5A5_0F0F);
    chk("R9 out kept", gpio_o, 32'h1234_5678);
    rd(8'h14, rv); chk("R9 read zero", rv, 32'h0);
    rd(8'h05, rv); chk("R9 unaligned zero", rv, 32'h0);
    // R8 unmask one pending bit
    wr(8'h18, ~32'h1); mask = ~32'h1; settle(1);
    chk("R8 irq", {31'h0, irq_o}, 32'h1);

    // random rounds
    for (int k = 0; k < 60; k++) begin
      logic [31:0] np, nq, ack, nm;
      np = $urandom; nq = $urandom; ack = $urandom | $urandom; nm = $urandom | $urandom;
      wr(8'h08, nq); pol = nq;
      settle(1); exp_stat |= hit_of(pins, pol);
      @(negedge clk_i); gpio_i = np;
      settle(4); pins = np; exp_stat |= hit_of(pins, pol);
      wr(8'h0C, ack); exp_stat = (exp_stat & ack) | hit_of(pins, pol);
      wr(8'h18, nm); mask = nm;
      rd(8'h0C, rv); chk("R5 rand status", rv, exp_stat);
      rd(8'h10, rv); chk("R6 rand pending", rv, exp_stat);
      chk("R8 rand irq", {31'h0, irq_o}, {31'h0, |(exp_stat & ~mask)});
    end

    // R7 mask all again
    wr(8'h18, 32'hFFFF_FFFF); settle(1);
    chk("R7 all masked", {31'h0, irq_o}, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule